// File: doc/BRIEF.md
# Destination-Chain DMA Receive Engine

This engine empties a 32-bit word FIFO into memory one 128-bit quadword at a time. Each quadword is built from four words popped in turn from a show-ahead FIFO, then offered to a memory write port. The write port holds the request until a single ready signal accepts it.

In normal mode the engine moves a quadword count that is loaded at start, beginning at a base address that is also loaded at start. In chain mode, each time the count runs out the engine takes a four-word descriptor from the same FIFO. The descriptor supplies the next packet's address, its quadword count and its control bits. The descriptor kind can close the chain, and two kinds also update a stall-address output.

When the work is finished the engine raises a one-cycle done interrupt and reports how many quadwords it wrote. That pulse is also the signal for the surrounding logic to clear the channel start bit. Dropping the start bit in the middle of a run stops the engine quietly, with no interrupt.

Top module: `dchain_rx`

## Requirements
- R1: A rising edge of `ch_start` while idle loads `base_addr` and `base_qwc` as the current address and count, clears the end flag and the quadword tally, and raises `busy` on the next cycle.
- R2: A quadword is collected only after a decision cycle that sees `fifo_count` >= 4. Its four words are popped on four consecutive cycles, and the first word popped lands in bits 31:0 of the quadword, the fourth in bits 127:96. No word is popped while a write is pending.
- R3: `mem_wr` stays high with `mem_addr` and `mem_data` unchanged until `mem_ready` is seen. Each accepted write adds 16 to the address and takes 1 from the remaining count.
- R4: With the count at zero in normal mode (`ch_chain`=0), the engine goes idle and pulses `done_irq` high for exactly one cycle.
- R5: With the count at zero in chain mode (`ch_chain`=1) and the end flag clear, the engine reads a 4-word descriptor once `fifo_count` >= 4. In word 0, bits 15:0 give the quadword count, bits 30:28 the kind and bit 31 the IRQ flag. Word 1 is the new address, and words 2 and 3 are discarded.
- R6: A descriptor whose IRQ bit (word 0 bit 31) is set ends the chain after its packet when `tie_en`=1. With `tie_en`=0 the IRQ bit has no effect.
- R7: Descriptor kind 7 (last packet) and kind 0 (last packet by reference) end the chain after their packet. Kinds 1 to 6 let the chain continue.
- R8: A descriptor of kind 0 or kind 4 loads `stall_addr` with (word 1 + count×16) when `stall_en`=1. `stall_en`=0 leaves `stall_addr` unchanged, and so do all other kinds.
- R9: `done_cycles`, valid with `done_irq`, equals the number of quadwords written during the run. A run that writes nothing reports 1.
- R10: If `ch_start` is found low at a decision point while busy, the engine goes idle with no `done_irq`. After that it pops and writes nothing until a new rising edge of `ch_start`.
- R11: With fewer than 4 words in the FIFO, the engine pops nothing and waits busy. It resumes once 4 words are available.
- R12: After reset the engine is idle: `busy`, `mem_wr`, `fifo_rd` and `done_irq` are low and `stall_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_start | input | 1 | Channel start bit (run on rising edge, abort when low) |
| ch_chain | input | 1 | 0 = normal mode, 1 = chain mode |
| tie_en | input | 1 | Honour the descriptor IRQ bit as end of chain |
| stall_en | input | 1 | Stall control enabled |
| base_addr | input | ADDR_W | Start address loaded at start |
| base_qwc | input | 16 | Quadword count loaded at start |
| fifo_count | input | CNT_W | Words held in the FIFO |
| fifo_rd | output | 1 | Pop the head word |
| fifo_rdata | input | 32 | Head word of the FIFO (show-ahead) |
| mem_wr | output | 1 | Write request |
| mem_addr | output | ADDR_W | Write byte address |
| mem_data | output | 128 | Write quadword |
| mem_ready | input | 1 | Write accepted this cycle |
| stall_addr | output | ADDR_W | Stall address register |
| busy | output | 1 | Engine active |
| done_irq | output | 1 | One-cycle completion interrupt; also clears the start bit |
| done_cycles | output | CYC_W | Quadwords written in the run, at least 1 |

## Verification
The normal path is tried with several counts: a multi-quadword run with a full FIFO, a zero count, a count larger than the FIFO contents, and a run with the memory held not ready. Together these separate the burst arithmetic, the minimum tally, starvation and write hold.

Chain runs are built from different descriptor kinds with the IRQ bit set and clear, and with tie-enable and stall-enable both on and off. A spare descriptor is left in the FIFO to show exactly where each chain stops. The stall address is checked after each kind to show which kinds load it.

An abort run followed by fresh FIFO data shows that a cleared start bit ends the engine without an interrupt.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
    localparam int WORD_W    = 32;
    localparam int QW_WORDS  = 4;
    localparam int QW_W      = WORD_W * QW_WORDS;
    localparam int IDX_W     = $clog2(QW_WORDS);
    localparam int TAG_QWC_W = 16;
    localparam int QW_BYTES_LOG2 = 4;

    typedef enum logic [2:0] {
        K_LAST_REF = 3'd0,
        K_COUNT    = 3'd1,
        K_FOLLOW   = 3'd2,
        K_REF      = 3'd3,
        K_REF_STL  = 3'd4,
        K_CALL     = 3'd5,
        K_RETURN   = 3'd6,
        K_LAST     = 3'd7
    } tag_kind_e;

    typedef struct packed {
        logic                 irq;
        tag_kind_e            kind;
        logic [TAG_QWC_W-1:0] qwc;
    } tag_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_FILL,
        ST_APPLY,
        ST_WRITE
    } state_e;

    function automatic logic kind_ends(input tag_kind_e k);
        return (k == K_LAST_REF) || (k == K_LAST);
    endfunction

    function automatic logic kind_sets_stall(input tag_kind_e k);
        return (k == K_LAST_REF) || (k == K_REF_STL);
    endfunction
endpackage

// File: rtl/dchain_tagdec.sv
module dchain_tagdec
    import dchain_pkg::*;
(
    input  logic [WORD_W-1:0] word0,
    output tag_t              tag
);
    always_comb begin
        tag.qwc  = word0[TAG_QWC_W-1:0];
        tag.kind = tag_kind_e'(word0[30:28]);
        tag.irq  = word0[31];
    end
endmodule

// File: rtl/dchain_qwpack.sv
module dchain_qwpack
    import dchain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [IDX_W-1:0]  slot,
    input  logic [WORD_W-1:0] wdata,
    output logic [QW_W-1:0]   qw
);
    logic [WORD_W-1:0] slot_q [QW_WORDS];

    for (genvar g = 0; g < QW_WORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (push && slot == IDX_W'(g))
                slot_q[g] <= wdata;
        end
        assign qw[g*WORD_W +: WORD_W] = slot_q[g];
    end
endmodule

// File: rtl/dchain_rx.sv
module dchain_rx
    import dchain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int CYC_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ch_start,
    input  logic                 ch_chain,
    input  logic                 tie_en,
    input  logic                 stall_en,
    input  logic [ADDR_W-1:0]    base_addr,
    input  logic [TAG_QWC_W-1:0] base_qwc,
    input  logic [CNT_W-1:0]     fifo_count,
    output logic                 fifo_rd,
    input  logic [WORD_W-1:0]    fifo_rdata,
    output logic                 mem_wr,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [QW_W-1:0]      mem_data,
    input  logic                 mem_ready,
    output logic [ADDR_W-1:0]    stall_addr,
    output logic                 busy,
    output logic                 done_irq,
    output logic [CYC_W-1:0]     done_cycles
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(QW_WORDS - 1);
    localparam logic [ADDR_W-1:0] QW_STEP = ADDR_W'(1) << QW_BYTES_LOG2;

    state_e               state_q;
    logic                 start_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [TAG_QWC_W-1:0] qwc_q;
    logic                 end_q;
    logic                 is_tag_q;
    logic [IDX_W-1:0]     idx_q;
    logic [CYC_W-1:0]     tally_q;
    logic [ADDR_W-1:0]    stall_q;
    logic                 done_q;
    logic [CYC_W-1:0]     dcyc_q;

    logic [QW_W-1:0]      qw;
    tag_t                 tag;
    logic [ADDR_W-1:0]    tag_addr;
    logic                 have_qw;
    logic                 start_rise;

    dchain_qwpack u_pack (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_rd),
        .slot  (idx_q),
        .wdata (fifo_rdata),
        .qw    (qw)
    );

    dchain_tagdec u_tag (
        .word0 (qw[WORD_W-1:0]),
        .tag   (tag)
    );

    assign tag_addr   = ADDR_W'(qw[2*WORD_W-1:WORD_W]);
    assign have_qw    = fifo_count >= CNT_W'(QW_WORDS);
    assign start_rise = ch_start && !start_q;

    assign fifo_rd     = (state_q == ST_FILL);
    assign mem_wr      = (state_q == ST_WRITE);
    assign mem_addr    = addr_q;
    assign mem_data    = qw;
    assign stall_addr  = stall_q;
    assign busy        = (state_q != ST_IDLE);
    assign done_irq    = done_q;
    assign done_cycles = dcyc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            start_q  <= 1'b0;
            addr_q   <= '0;
            qwc_q    <= '0;
            end_q    <= 1'b0;
            is_tag_q <= 1'b0;
            idx_q    <= '0;
            tally_q  <= '0;
            stall_q  <= '0;
            done_q   <= 1'b0;
            dcyc_q   <= '0;
        end else begin
            start_q <= ch_start;
            done_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_rise) begin
                        addr_q  <= base_addr;
                        qwc_q   <= base_qwc;
                        end_q   <= 1'b0;
                        tally_q <= '0;
                        state_q <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    if (!ch_start) begin
                        end_q   <= 1'b0;
                        state_q <= ST_IDLE;
                    end else if (qwc_q == '0) begin
                        if (!ch_chain || end_q) begin
                            end_q   <= 1'b0;
                            done_q  <= 1'b1;
                            dcyc_q  <= (tally_q == '0) ? CYC_W'(1) : tally_q;
                            state_q <= ST_IDLE;
                        end else if (have_qw) begin
                            is_tag_q <= 1'b1;
                            idx_q    <= '0;
                            state_q  <= ST_FILL;
                        end
                    end else if (have_qw) begin
                        is_tag_q <= 1'b0;
                        idx_q    <= '0;
                        state_q  <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_IDX)
                        state_q <= is_tag_q ? ST_APPLY : ST_WRITE;
                end
                ST_APPLY: begin
                    qwc_q  <= tag.qwc;
                    addr_q <= tag_addr;
                    end_q  <= end_q | (tie_en & tag.irq) | kind_ends(tag.kind);
                    if (stall_en && kind_sets_stall(tag.kind))
                        stall_q <= tag_addr + (ADDR_W'(tag.qwc) << QW_BYTES_LOG2);
                    state_q <= ST_DECIDE;
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        addr_q  <= addr_q + QW_STEP;
                        qwc_q   <= qwc_q - 1'b1;
                        tally_q <= tally_q + 1'b1;
                        state_q <= ST_DECIDE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dchain_rx_chk.sv
module dchain_rx_chk
    import dchain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int CYC_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              fifo_rd,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [QW_W-1:0]   mem_data,
    input logic              busy,
    input logic              done_irq,
    input logic [CYC_W-1:0]  done_cycles
);
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_data))); // R3

    AST_NO_POP_DURING_WR: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !fifo_rd); // R2

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq); // R4

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> !busy); // R4

    AST_CYCLES_MIN: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> (done_cycles != '0)); // R9

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (fifo_count != '0)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_wr && !fifo_rd)); // R12
endmodule

bind dchain_rx dchain_rx_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_chk (.*);

// File: tb/dchain_rx_tb.sv
module dchain_rx_tb;
    import dchain_pkg::*;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 8;
    localparam int CYC_W  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ch_start = 0, ch_chain = 0, tie_en = 0, stall_en = 0, mem_ready = 1;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [15:0] base_qwc = '0;
    logic [CNT_W-1:0] fifo_count;
    logic fifo_rd, mem_wr, busy, done_irq;
    logic [WORD_W-1:0] fifo_rdata;
    logic [ADDR_W-1:0] mem_addr, stall_addr;
    logic [QW_W-1:0] mem_data;
    logic [CYC_W-1:0] done_cycles;

    always #2 clk = ~clk;

    logic [31:0] fmem [0:63];
    int wp = 0, rp = 0;
    assign fifo_count = CNT_W'(wp - rp);
    assign fifo_rdata = fmem[rp[5:0]];

    logic [ADDR_W-1:0] wr_addr [0:15];
    logic [QW_W-1:0]   wr_data [0:15];
    int nwr = 0, nirq = 0;
    logic [CYC_W-1:0] last_cyc = '0;
    int total = 0, bad = 0, ticks = 0;

    dchain_rx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_dut (.*);

    always @(posedge clk) begin
        if (fifo_rd) rp <= rp + 1;
        if (mem_wr && mem_ready) begin
            wr_addr[nwr[3:0]] <= mem_addr;
            wr_data[nwr[3:0]] <= mem_data;
            nwr <= nwr + 1;
        end
        if (done_irq) begin
            nirq <= nirq + 1;
            last_cyc <= done_cycles;
        end
        ticks <= ticks + 1;
        if (ticks == 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        fmem[wp[5:0]] = w;
        wp = wp + 1;
    endtask

    task automatic push_data(input int n, input logic [31:0] seed);
        for (int i = 0; i < n; i++) push(seed + 32'(i));
    endtask

    task automatic push_tag(input logic [31:0] w0, input logic [31:0] w1);
        push(w0); push(w1); push(32'hDEAD_0002); push(32'hDEAD_0003);
    endtask

    task automatic clear_all();
        @(negedge clk);
        wp = 0; rp = 0; nwr = 0; nirq = 0;
    endtask

    task automatic launch(input logic chain, input logic [31:0] a, input logic [15:0] q);
        @(negedge clk);
        ch_chain = chain; base_addr = a; base_qwc = q; ch_start = 1;
    endtask

    task automatic finish_run();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        ch_start = 0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [127:0] qw_of(input logic [31:0] seed);
        return {seed + 32'd3, seed + 32'd2, seed + 32'd1, seed};
    endfunction

    task automatic t_reset();
        chk(!busy && !mem_wr && !fifo_rd && !done_irq && stall_addr == 0, "R12 reset idle",
            {busy, mem_wr, fifo_rd, done_irq}, 0);
    endtask

    task automatic t_normal();
        clear_all();
        push_data(12, 32'hA000_0100);
        launch(0, 32'h1000, 3);
        @(negedge clk);
        chk(busy, "R1 busy after start", busy, 1);
        finish_run();
        chk(nwr == 3, "R4 normal write count", nwr, 3);
        for (int i = 0; i < 3; i++) begin
            chk(wr_addr[i] == 32'h1000 + 32'(16*i), "R3 address step", wr_addr[i], 32'h1000 + 32'(16*i));
            chk(wr_data[i] == qw_of(32'hA000_0100 + 32'(4*i)), "R2 word packing", wr_data[i],
                qw_of(32'hA000_0100 + 32'(4*i)));
        end
        chk(nirq == 1, "R4 one interrupt", nirq, 1);
        chk(last_cyc == 3, "R9 tally", last_cyc, 3);
        chk(fifo_count == 0, "R2 fifo drained", fifo_count, 0);
    endtask

    task automatic t_zero();
        clear_all();
        launch(0, 32'h1000, 0);
        finish_run();
        chk(nwr == 0 && nirq == 1, "R4 zero count finishes", nwr, 0);
        chk(last_cyc == 1, "R9 minimum tally", last_cyc, 1);
    endtask

    task automatic t_chain();
        clear_all();
        stall_en = 1;
        push_tag(32'h1000_0002, 32'h2000);
        push_data(8, 32'hB000_0000);
        push_tag(32'h7000_0001, 32'h3000);
        push_data(4, 32'hC000_0000);
        launch(1, 32'hFFF0, 0);
        finish_run();
        chk(nwr == 3, "R5 chain writes", nwr, 3);
        chk(wr_addr[0] == 32'h2000 && wr_addr[1] == 32'h2010, "R5 tag address", wr_addr[1], 32'h2010);
        chk(wr_addr[2] == 32'h3000 && wr_data[2] == qw_of(32'hC000_0000), "R7 last kind packet",
            wr_addr[2], 32'h3000);
        chk(fifo_count == 0 && nirq == 1, "R7 last kind ends", fifo_count, 0);
        chk(last_cyc == 3, "R9 chain tally", last_cyc, 3);
        chk(stall_addr == 0, "R8 other kinds keep stall", stall_addr, 0);
    endtask

    task automatic t_tie(input logic en);
        clear_all();
        tie_en = en;
        push_tag(32'h9000_0002, 32'h0009_35C0);
        push_data(8, 32'hD000_0000);
        push_tag(32'h7000_0000, 32'h7777);
        launch(1, 0, 0);
        finish_run();
        chk(nwr == 2 && wr_addr[1] == 32'h0009_35D0, "R6 irq packet written", wr_addr[1], 32'h0009_35D0);
        if (en) chk(fifo_count == 4, "R6 tie stops chain", fifo_count, 4);
        else    chk(fifo_count == 0, "R6 irq bit ignored", fifo_count, 0);
        chk(nirq == 1, "R6 interrupt", nirq, 1);
        tie_en = 0;
    endtask

    task automatic t_stall();
        clear_all();
        stall_en = 1;
        push_tag(32'h0000_0002, 32'h4000);
        push_data(8, 32'hE000_0000);
        push_tag(32'h7000_0000, 32'h8888);
        launch(1, 0, 0);
        finish_run();
        chk(stall_addr == 32'h4020, "R8 ref-last loads stall", stall_addr, 32'h4020);
        chk(fifo_count == 4 && nwr == 2, "R7 ref-last ends chain", fifo_count, 4);
        clear_all();
        push_tag(32'h4000_0001, 32'h5000);
        push_data(4, 32'hF000_0000);
        push_tag(32'h7000_0000, 32'h9999);
        launch(1, 0, 0);
        finish_run();
        chk(stall_addr == 32'h5010, "R8 ref-stall loads stall", stall_addr, 32'h5010);
        chk(nwr == 1 && fifo_count == 0, "R7 kind 4 continues", fifo_count, 0);
        clear_all();
        stall_en = 0;
        push_tag(32'h4000_0001, 32'h6000);
        push_data(4, 32'h1100_0000);
        push_tag(32'h7000_0000, 32'h9999);
        launch(1, 0, 0);
        finish_run();
        chk(stall_addr == 32'h5010, "R8 stall disabled keeps value", stall_addr, 32'h5010);
    endtask

    task automatic t_abort();
        clear_all();
        launch(1, 0, 0);
        repeat (5) @(negedge clk);
        chk(busy, "R10 waiting busy", busy, 1);
        ch_start = 0;
        repeat (3) @(negedge clk);
        chk(!busy && nirq == 0, "R10 abort without irq", nirq, 0);
        push_tag(32'h1000_0001, 32'hAAAA);
        push_data(4, 32'h2200_0000);
        repeat (20) @(negedge clk);
        chk(nwr == 0 && fifo_count == 8, "R10 nothing after abort", fifo_count, 8);
    endtask

    task automatic t_backpressure();
        clear_all();
        mem_ready = 0;
        push_data(4, 32'h3300_0000);
        launch(0, 32'h7000, 1);
        repeat (10) @(negedge clk);
        chk(mem_wr && mem_addr == 32'h7000 && mem_data == qw_of(32'h3300_0000), "R3 write held",
            mem_addr, 32'h7000);
        mem_ready = 1;
        finish_run();
        chk(nwr == 1 && last_cyc == 1, "R3 write accepted once", nwr, 1);
    endtask

    task automatic t_starve();
        clear_all();
        push_data(5, 32'h4400_0000);
        launch(0, 32'h8000, 2);
        repeat (30) @(negedge clk);
        chk(nwr == 1 && busy && fifo_count == 1, "R11 waits for four words", fifo_count, 1);
        push_data(3, 32'h4400_0005);
        finish_run();
        chk(nwr == 2 && wr_data[1] == qw_of(32'h4400_0004), "R11 resumes", wr_data[1], qw_of(32'h4400_0004));
        chk(nirq == 1 && last_cyc == 2, "R9 starved tally", last_cyc, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_zero();
        t_chain();
        t_tie(1);
        t_tie(0);
        t_stall();
        t_abort();
        t_backpressure();
        t_starve();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule